// File: doc/BRIEF.md
# Line Voltage Sag Detector

This block watches the filtered voltage-channel sample stream of a metering datapath and reports a line sag. The stream is cut into half line cycles by a strobe from an upstream zero-crossing generator. The block takes the magnitude of each signed sample and picks one byte out of it. It compares that byte against a programmable level. When no sample in a half cycle reaches the level, that half cycle counts as low. Once a programmable number of consecutive half cycles have been low, the active-low sag pin falls. A one-cycle event pulse is also sent to an interrupt controller.

The pin recovers on the first sample that reaches the level again, even in the middle of a half cycle. A disable bit stops the pin from showing a sag but does not suppress the event pulse. Three configuration values are loaded through a small parallel write port: the level, the half-cycle count and the disable bit.

Top module: `sag_detector`

## Requirements
- R1: For each valid sample, the compared byte is bits [18:11] of the sample's absolute value. This is the top byte after a one-bit left shift. The sample is low when the level register is strictly greater than this byte, and reaches the level otherwise. Level 0x00 never flags a sample low, and a full-scale magnitude 0x257F6 yields byte 0x4A.
- R2: The absolute value of the most negative sample (-2^19) saturates to 0x7FFFF, so its byte is 0xFF.
- R3: A half cycle counts as low only if no valid sample inside it reaches the level. A sample on the closing strobe cycle belongs to the closing half cycle. Any reaching sample restarts the consecutive count.
- R4: With count register N, the sag pin goes low on the clock edge that ends the Nth consecutive low half cycle, and is visible right after that edge. N = 0 behaves like N = 1. A strobe with no samples at all is a low half cycle.
- R5: While a sag is active, the first valid sample that reaches the level ends it on that clock edge. No strobe is needed for this.
- R6: With the disable bit set, an active sag does not pull the pin low, but the event pulse still fires. Clearing the bit while the sag persists drives the pin low on the next cycle.
- R7: `sag_evt` is high for exactly one cycle per sag entry, on the same edge as the entry, and not again while the sag continues.
- R8: Synchronous reset gives level 0x00, count 0x00, disable 0, no event, and the pin driven low. After reset the pin is released only at a strobe ending a half cycle that contained a reaching sample. A reaching sample in mid half cycle does not release it.
- R9: A write with `wr_en` high loads the register chosen by `wr_sel`, and the new value acts from the next cycle. The encodings are: 0 = level, 1 = half-cycle count, 2 = disable bit (taken from `wr_data[0]`). Select 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 level, 1 count, 2 disable, 3 ignored) |
| wr_data | input | 8 | Write data |
| smp_valid | input | 1 | Sample valid strobe |
| smp_data | input | 20 | Signed two's complement voltage sample |
| half_cyc | input | 1 | One-cycle strobe closing the current half line cycle |
| sag_n | output | 1 | Active-low sag pin |
| sag_evt | output | 1 | One-cycle sag entry pulse for the interrupt status logic |

## Verification
Some properties are checked on every cycle by the in-line assertions:
- an entry pulse only ever comes with a fresh sag;
- a sag starts only at a strobe edge;
- a reaching sample both clears the run counter and ends an active sag;
- the post-reset hold ends only at a strobe.

Other behaviour can only be shown by the bench scenarios. The bench sweeps the full strict comparison over every byte value at several levels, with samples of both signs. It also checks the saturated magnitude of the most negative sample and the exact half cycle at which the pin falls for different counts. The remaining cases are the disable-bit interplay, the reset hold and the ignored select code.

// File: rtl/sag_pkg.sv
// Shared definitions for the sag detector.
// Assumes: the write select is two bits wide.
package sag_pkg;
    typedef enum logic [1:0] {
        SEL_LEVEL  = 2'd0,
        SEL_CYCLES = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_SPARE  = 2'd3
    } wr_sel_e;
endpackage

// File: rtl/sag_cfg_regs.sv
// Configuration registers written through a parallel port.
// Assumes: WR_W covers both LEVEL_W and COUNT_W; select code 3 writes nothing.
module sag_cfg_regs
    import sag_pkg::*;
#(
    parameter int LEVEL_W = 8,
    parameter int COUNT_W = 8,
    parameter int WR_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [WR_W-1:0]    wr_data,
    output logic [LEVEL_W-1:0] level_q,
    output logic [COUNT_W-1:0] cycles_q,
    output logic               dis_q
);
    wr_sel_e sel;
    assign sel = wr_sel_e'(wr_sel);

    // Load the selected register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q  <= '0;
            cycles_q <= '0;
            dis_q    <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_LEVEL:  level_q  <= wr_data[LEVEL_W-1:0];
                SEL_CYCLES: cycles_q <= wr_data[COUNT_W-1:0];
                SEL_CTRL:   dis_q    <= wr_data[0];
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/sag_level_cmp.sv
// Forms the saturated magnitude of a signed sample.
// Takes the byte below the magnitude's top bit and flags the sample low when the level is strictly greater.
// Assumes: SAMPLE_W - 1 >= LEVEL_W.
module sag_level_cmp #(
    parameter int SAMPLE_W = 20,
    parameter int LEVEL_W  = 8
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic [LEVEL_W-1:0]         level,
    output logic                       below
);
    localparam int TOP = SAMPLE_W - 2;
    localparam int LOW = SAMPLE_W - 1 - LEVEL_W;
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam logic [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

    logic [SAMPLE_W-1:0] mag;
    logic [LEVEL_W-1:0]  cmp_byte;
    logic                unused_bits;

    // Saturating absolute value; the most negative input maps to the most positive value.
    always_comb begin
        if (sample == MOST_NEG)
            mag = MOST_POS;
        else if (sample[SAMPLE_W-1])
            mag = -sample;
        else
            mag = sample;
    end

    assign cmp_byte    = mag[TOP:LOW];
    assign below       = level > cmp_byte;
    assign unused_bits = ^{mag[SAMPLE_W-1], mag[LOW-1:0]};
endmodule

// File: rtl/sag_half_tracker.sv
// Tracks half-cycle peaks against the level, counts consecutive low half cycles,
// and holds the sag state, the post-reset hold and the entry pulse.
// Assumes: half_cyc is a one-cycle strobe; a sample on the strobe cycle belongs to the closing half.
module sag_half_tracker #(
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic               below,
    input  logic               half_cyc,
    input  logic [COUNT_W-1:0] cycles,
    output logic               sag_act,
    output logic               hold,
    output logic               sag_evt
);
    logic               hit;
    logic               seen_hi;
    logic               half_high;
    logic               enter;
    logic [COUNT_W-1:0] run_cnt;
    logic [COUNT_W-1:0] cnt_inc;

    assign hit       = smp_valid & ~below;
    assign half_high = seen_hi | hit;
    assign cnt_inc   = (&run_cnt) ? run_cnt : run_cnt + COUNT_W'(1);
    assign enter     = half_cyc & ~half_high & ~sag_act & (cnt_inc >= cycles);

    // Remember whether the current half cycle has reached the level.
    always_ff @(posedge clk) begin
        if (!rst_n)        seen_hi <= 1'b0;
        else if (half_cyc) seen_hi <= 1'b0;
        else if (hit)      seen_hi <= 1'b1;
    end

    // Count consecutive low half cycles, saturating; any reaching sample restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)        run_cnt <= '0;
        else if (hit)      run_cnt <= '0;
        else if (half_cyc) run_cnt <= seen_hi ? '0 : cnt_inc;
    end

    // Sag state: set at a qualifying strobe, cleared by any reaching sample.
    always_ff @(posedge clk) begin
        if (!rst_n)     sag_act <= 1'b0;
        else if (hit)   sag_act <= 1'b0;
        else if (enter) sag_act <= 1'b1;
    end

    // One pulse per sag entry.
    always_ff @(posedge clk) begin
        if (!rst_n) sag_evt <= 1'b0;
        else        sag_evt <= enter;
    end

    // Post-reset hold, released at the first strobe ending a reaching half cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                     hold <= 1'b1;
        else if (half_cyc && half_high) hold <= 1'b0;
    end

    p_evt_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sag_evt |-> (sag_act && !$past(sag_act)));

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sag_act && smp_valid && !below) |=> !sag_act);

    p_enter_at_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sag_act) |-> $past(half_cyc));

    p_count_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !below) |=> (run_cnt == '0));

    p_hold_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> $past(half_cyc));
endmodule

// File: rtl/sag_detector.sv
// Line voltage sag detector top level.
// Joins the configuration port, the level compare and the half-cycle tracker, and drives the active-low pin.
// Assumes: samples are signed two's complement from the filtered voltage channel.
module sag_detector #(
    parameter int SAMPLE_W = 20,
    parameter int LEVEL_W  = 8,
    parameter int COUNT_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_sel,
    input  logic [((LEVEL_W > COUNT_W) ? LEVEL_W : COUNT_W)-1:0] wr_data,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic                       half_cyc,
    output logic                       sag_n,
    output logic                       sag_evt
);
    localparam int WR_W = (LEVEL_W > COUNT_W) ? LEVEL_W : COUNT_W;

    logic [LEVEL_W-1:0] level_q;
    logic [COUNT_W-1:0] cycles_q;
    logic               dis_q;
    logic               below;
    logic               sag_act;
    logic               hold;

    sag_cfg_regs #(
        .LEVEL_W (LEVEL_W),
        .COUNT_W (COUNT_W),
        .WR_W    (WR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .level_q  (level_q),
        .cycles_q (cycles_q),
        .dis_q    (dis_q)
    );

    sag_level_cmp #(
        .SAMPLE_W (SAMPLE_W),
        .LEVEL_W  (LEVEL_W)
    ) u_cmp (
        .sample (smp_data),
        .level  (level_q),
        .below  (below)
    );

    sag_half_tracker #(
        .COUNT_W (COUNT_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .below     (below),
        .half_cyc  (half_cyc),
        .cycles    (cycles_q),
        .sag_act   (sag_act),
        .hold      (hold),
        .sag_evt   (sag_evt)
    );

    // Pin is low during the post-reset hold, or for an enabled active sag.
    assign sag_n = ~(hold | (sag_act & ~dis_q));
endmodule

// File: tb/sag_detector_test.sv
`timescale 1ns/1ps
module sag_detector_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [1:0]         wr_sel = 2'd0;
    logic [7:0]         wr_data = 8'd0;
    logic               smp_valid = 1'b0;
    logic signed [19:0] smp_data = '0;
    logic               half_cyc = 1'b0;
    logic               sag_n;
    logic               sag_evt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic signed [19:0] POS_MAX = 20'sh7FFFF;

    sag_detector uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .half_cyc  (half_cyc),
        .sag_n     (sag_n),
        .sag_evt   (sag_evt)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge; outputs are settled at the next falling edge.
    task automatic cyc(input logic v, input logic signed [19:0] d, input logic h);
        smp_valid = v;
        smp_data  = d;
        half_cyc  = h;
        @(negedge clk);
        smp_valid = 1'b0;
        half_cyc  = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_sel  = s;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Build a sample whose magnitude carries byte b in bits [18:11].
    function automatic logic signed [19:0] mk(input logic [7:0] b, input logic neg);
        logic signed [19:0] m;
        m = {1'b0, b, 11'(b * 37)};
        return neg ? -m : m;
    endfunction

    // End a half cycle that reached the level: clears the run and any sag.
    task automatic clear_run();
        cyc(1'b1, POS_MAX, 1'b0);
        cyc(1'b0, '0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lv;
        logic       exp_low;
        @(negedge clk);
        @(negedge clk);
        chk(sag_n, 1'b0, "R8 pin low in reset");
        @(negedge clk);
        rst_n = 1'b1;
        chk(sag_n, 1'b0, "R8 pin low after reset");
        chk(sag_evt, 1'b0, "R8 no event after reset");
        // Mid-cycle reaching sample must not release the hold (level 0 reaches always).
        cyc(1'b1, 20'sd5, 1'b0);
        chk(sag_n, 1'b0, "R8 hold kept mid half cycle");
        cyc(1'b0, '0, 1'b1);
        chk(sag_n, 1'b1, "R8 hold released at strobe");

        // R1 / R5 sweep: N=1, all bytes against several levels, both signs.
        wr(2'd1, 8'd1);
        for (int li = 0; li < 6; li++) begin
            case (li)
                0: lv = 8'h00;
                1: lv = 8'h01;
                2: lv = 8'h10;
                3: lv = 8'h4A;
                4: lv = 8'h80;
                default: lv = 8'hFF;
            endcase
            wr(2'd0, lv);
            for (int b = 0; b < 256; b++) begin
                clear_run();
                chk(sag_n, 1'b1, "R5 cleared before trial");
                exp_low = (lv > 8'(b));
                cyc(1'b1, mk(8'(b), b[0]), 1'b1);
                chk(sag_n, !exp_low, "R1 compare pin");
                chk(sag_evt, exp_low, "R1 compare event");
            end
        end

        // R1 full-scale points.
        wr(2'd0, 8'h4A);
        clear_run();
        cyc(1'b1, 20'sh257F6, 1'b1);
        chk(sag_n, 1'b1, "R1 full scale reaches 0x4A");
        wr(2'd0, 8'h4B);
        clear_run();
        cyc(1'b1, -20'sh257F6, 1'b1);
        chk(sag_n, 1'b0, "R1 full scale below 0x4B");

        // R2 saturation of the most negative sample.
        wr(2'd0, 8'hFF);
        clear_run();
        cyc(1'b1, 20'sh80000, 1'b1);
        chk(sag_n, 1'b1, "R2 most negative saturates to byte 0xFF");
        clear_run();
        cyc(1'b1, 20'sh7F7FF, 1'b1);
        chk(sag_n, 1'b0, "R2 byte 0xFE below 0xFF");

        // R4: N=6, pin falls exactly at the end of the sixth low half.
        wr(2'd0, 8'h40);
        wr(2'd1, 8'd6);
        clear_run();
        for (int h = 1; h <= 6; h++) begin
            cyc(1'b1, mk(8'h20, 1'b0), 1'b0);
            cyc(1'b1, mk(8'h3F, 1'b1), 1'b0);
            cyc(1'b0, '0, 1'b0);
            cyc(1'b1, mk(8'h10, 1'b0), 1'b1);
            chk(sag_n, (h < 6), "R4 N=6 half cycle count");
            chk(sag_evt, (h == 6), "R7 event at entry only");
        end
        // R7: sag persists, no further event.
        cyc(1'b0, '0, 1'b0);
        chk(sag_evt, 1'b0, "R7 event is one cycle");
        cyc(1'b1, mk(8'h05, 1'b0), 1'b1);
        chk(sag_n, 1'b0, "R7 sag persists");
        chk(sag_evt, 1'b0, "R7 no repeat event");
        // R5: low samples mid half keep it, one reaching sample ends it at once.
        cyc(1'b1, mk(8'h30, 1'b1), 1'b0);
        chk(sag_n, 1'b0, "R5 low sample keeps sag");
        cyc(1'b1, mk(8'h40, 1'b1), 1'b0);
        chk(sag_n, 1'b1, "R5 release mid half cycle");

        // R3: a reaching sample inside a half cycle restarts the count (N=3).
        wr(2'd1, 8'd3);
        clear_run();
        cyc(1'b1, mk(8'h01, 1'b0), 1'b1);
        cyc(1'b0, '0, 1'b1);
        cyc(1'b1, mk(8'h41, 1'b0), 1'b0);
        cyc(1'b1, mk(8'h01, 1'b0), 1'b1);
        chk(sag_n, 1'b1, "R3 reaching half not low");
        cyc(1'b1, mk(8'h01, 1'b0), 1'b1);
        cyc(1'b1, mk(8'h02, 1'b1), 1'b1);
        chk(sag_n, 1'b1, "R3 count restarted");
        cyc(1'b0, '0, 1'b1);
        chk(sag_n, 1'b0, "R3 third low half after restart");
        chk(sag_evt, 1'b1, "R4 empty half counts low");

        // R4: N=0 acts as N=1.
        wr(2'd1, 8'd0);
        clear_run();
        cyc(1'b1, mk(8'h01, 1'b0), 1'b1);
        chk(sag_n, 1'b0, "R4 N=0 behaves as 1");

        // R6: disable bit masks the pin but not the event.
        wr(2'd1, 8'd1);
        wr(2'd2, 8'h01);
        clear_run();
        cyc(1'b1, mk(8'h01, 1'b0), 1'b1);
        chk(sag_n, 1'b1, "R6 pin masked by disable");
        chk(sag_evt, 1'b1, "R6 event despite disable");
        wr(2'd2, 8'h00);
        chk(sag_n, 1'b0, "R6 pin low after enabling");
        cyc(1'b1, POS_MAX, 1'b0);
        chk(sag_n, 1'b1, "R5 release after enable");

        // R9: select 3 is ignored, level stays 0x40.
        wr(2'd0, 8'h40);
        wr(2'd3, 8'h00);
        clear_run();
        cyc(1'b1, mk(8'h30, 1'b0), 1'b1);
        chk(sag_n, 1'b0, "R9 select 3 ignored");
        chk(sag_evt, 1'b1, "R9 level kept");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule